// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a small synchronous static memory with a pipelined access path. It stores words of 18 bits, and each word is split into two 9-bit byte lanes. An access starts on a clock edge where one of two address strobes is active. The edge captures the address, the chip selects and the write controls. Up to three more beats of the same four-word group are then reached through an internal 2-bit burst counter, which steps on edges where the advance input is low. The counter follows either an interleaved order or a linear wrapping order. Which order applies is fixed when the burst starts.

Every input is registered before it reaches the array, and read data is registered again on its way out. A read strobed on one edge therefore shows its data after the next edge, and each later beat follows one clock after the beat before it. Writes go to the array one edge after their controls are captured, and they use the registered address, data and lane mask. Read data is driven only while the asynchronous output enable is low. Separate data-in and data-out ports stand in for a shared bus, and a valid flag marks the cycles in which the output carries data.

Top module: `psb_sram`

## Requirements
- R1: While and just after reset, `dout_valid` is 0 and `dout` is all zeros.
- R2: A read captured on edge E appears on `dout`, with `dout_valid` high, after edge E+1 and until edge E+2, provided `oe_n` is low.
- R3: Lane A is bits [8:0] and lane B is bits [17:9]. With `all_wr_n` low, a write stores both lanes, whatever `lane_wr_en_n` and `lane_sel_n` say.
- R4: With `all_wr_n` high and `lane_wr_en_n` low, only lanes whose `lane_sel_n` bit is 0 are stored (bit 0 is lane A, bit 1 is lane B), and the other lanes keep their contents. A write beat produces no output beat. With both `all_wr_n` and `lane_wr_en_n` high, the beat is a read.
- R5: A strobe selects the block only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A controller strobe (`strobe_ctl_n` low) that is not selected performs no access and ends any running burst, so later advances produce nothing.
- R6: A processor strobe (`strobe_cpu_n` low) is ignored while `sel0_n` is high, and a running burst then proceeds as if no strobe had come. A processor-strobe beat is always a read, whatever the write inputs say. When both strobes are low, the processor strobe governs.
- R7: With `burst_linear`=0 at the strobe, beat k (k=0..3) addresses start[1:0] XOR k, and the upper address bits stay fixed.
- R8: With `burst_linear`=1 at the strobe, beat k addresses (start[1:0]+k) mod 4, and the upper address bits stay fixed.
- R9: On an edge with no strobe and `adv_n` low, a running burst issues its next beat, which uses the write controls and `din` sampled on that edge. With `adv_n` high, no access is issued and the counter holds its value.
- R10: After the fourth beat, further advances issue no access. A selected strobe in the middle of a burst starts a new burst at the new address, with the counter cleared.
- R11: `oe_n` high forces `dout` to zero and `dout_valid` low at once, and it leaves the pipeline and the array untouched.
- R12: A read strobed on the edge right after a write beat returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control and output state |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write of both lanes, active low |
| lane_wr_en_n | input | 1 | Enable for per-lane writes, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low; bit 0 lane A, bit 1 lane B |
| burst_linear | input | 1 | Burst order taken at the strobe: 1 linear, 0 interleaved |
| addr | input | 10 | Word address, taken at a strobe |
| din | input | 18 | Write data, sampled on every beat |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 18 | Registered read data; zero when not driven |
| dout_valid | output | 1 | High when `dout` carries read data |

## Verification
The bench keeps its own array and burst model and checks the outputs on every cycle. It sweeps every start offset in both burst orders. A design that mixed up XOR with addition would return the wrong words from the second beat on. The bench also tries all four lane-select patterns and global write with the lane selects inactive. A wrong mask decode would corrupt, or fail to update, the lane that should have kept its old value. Other cases test the control edges:
- a pause in the middle of a burst,
- advances past the fourth beat,
- a restart in the middle of a burst,
- a deselecting controller strobe,
- a processor strobe with `sel0_n` high,
- a processor strobe with writes asserted,
- a read right after a write.

A design that mishandled any of these would emit extra beats, skip beats, or store data it should have ignored, and the per-cycle comparison shows it at once.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int LANES = 2;

  function automatic logic chip_selected(input logic s0_n, input logic s1, input logic s2_n);
    return !s0_n && s1 && !s2_n;
  endfunction

  function automatic logic write_cycle(input logic gw_n, input logic lw_n);
    return !gw_n || !lw_n;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic lw_n,
                                                 input logic [LANES-1:0] ls_n);
    if (!gw_n) return '1;
    if (!lw_n) return ~ls_n;
    return '0;
  endfunction

  function automatic logic [1:0] burst_offset(input logic [1:0] start, input logic [1:0] k,
                                              input logic lin);
    return lin ? (start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic              req_valid,
  output logic              req_write,
  output logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_data
);
  logic              cpu_hit, ctl_hit, ev_load, chip_on, ev_step, ev_end;
  logic              wr_now;
  logic [LANES-1:0]  mask_now;
  logic              burst_on, burst_lin;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;

  always_comb begin
    cpu_hit  = !strobe_cpu_n && !sel0_n;
    ctl_hit  = !strobe_ctl_n;
    ev_load  = cpu_hit || ctl_hit;
    chip_on  = chip_selected(sel0_n, sel1, sel2_n);
    ev_step  = !ev_load && burst_on && !adv_n && (cnt_q != 2'd3);
    ev_end   = !ev_load && burst_on && !adv_n && (cnt_q == 2'd3);
    cnt_nxt  = cnt_q + 2'd1;
    wr_now   = write_cycle(all_wr_n, lane_wr_en_n);
    mask_now = lane_mask(all_wr_n, lane_wr_en_n, lane_sel_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on  <= 1'b0;
      burst_lin <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
    end else if (ev_load) begin
      burst_on  <= chip_on;
      burst_lin <= burst_linear;
      base_q    <= addr;
      cnt_q     <= '0;
    end else if (ev_end) begin
      burst_on  <= 1'b0;
    end else if (ev_step) begin
      cnt_q     <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_mask  <= '0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= (ev_load && chip_on) || ev_step;
      req_write <= ev_load ? (!cpu_hit && wr_now) : wr_now;
      req_mask  <= mask_now;
      req_data  <= din;
      req_addr  <= ev_load ? addr
                           : {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], cnt_nxt, burst_lin)};
    end
  end

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && !ev_load && adv_n) |=> ($stable(cnt_q) && !req_valid));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !chip_on) |=> (!burst_on && !req_valid));

  assert_cpu_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |=> !req_write);

  assert_burst_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (!burst_on && !req_valid));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && chip_on) |=> (cnt_q == 2'd0 && req_valid && req_addr == $past(addr)));
endmodule

// File: rtl/psb_lane.sv
module psb_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
    if (rd_en) rdata <= cells[addr];
  end
endmodule

// File: rtl/psb_outstage.sv
module psb_outstage #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= rd_issue;
  end

  always_comb begin
    dout_valid = valid_q && !oe_n;
    dout       = dout_valid ? word_in : '0;
  end
endmodule

// File: rtl/psb_sram.sv
module psb_sram
  import psb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);
  logic              req_valid, req_write;
  logic [LANES-1:0]  req_mask;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_data, rd_word;
  logic              rd_issue, wr_issue;

  assign rd_issue = req_valid && !req_write;
  assign wr_issue = req_valid && req_write;

  psb_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .burst_linear(burst_linear),
    .addr(addr), .din(din), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_data(req_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psb_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk(clk),
      .wr_en(wr_issue && req_mask[g]),
      .rd_en(rd_issue),
      .addr(req_addr),
      .wdata(req_data[g*LANE_W +: LANE_W]),
      .rdata(rd_word[g*LANE_W +: LANE_W])
    );
  end

  psb_outstage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .oe_n(oe_n),
    .word_in(rd_word), .dout(dout), .dout_valid(dout_valid)
  );

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> (oe_n || dout_valid));

  assert_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> !dout_valid);
endmodule

// File: tb/psb_sram_bench.sv
module psb_sram_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_n, ctl_n, adv_n, s0n, s1, s2n, gw_n, bwe_n, lin, oe_n;
  logic [1:0]  bw_n;
  logic [9:0]  addr;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_valid;

  int checks = 0;
  int failures = 0;

  logic [17:0] mmem [1024];
  logic        m_on, m_lin;
  logic [9:0]  m_base;
  int          m_cnt;
  logic        rq_v, rq_w;
  logic [1:0]  rq_mask;
  logic [9:0]  rq_addr;
  logic [17:0] rq_data;
  logic        ex_v;
  logic [17:0] ex_d;

  always #10 clk = ~clk;

  psb_sram u_psb_sram (
    .clk(clk), .rst_n(rst_n), .strobe_cpu_n(cpu_n), .strobe_ctl_n(ctl_n), .adv_n(adv_n),
    .sel0_n(s0n), .sel1(s1), .sel2_n(s2n), .all_wr_n(gw_n), .lane_wr_en_n(bwe_n),
    .lane_sel_n(bw_n), .burst_linear(lin), .addr(addr), .din(din), .oe_n(oe_n),
    .dout(dout), .dout_valid(dout_valid)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 1237) ^ 32'h2A5A5);
  endfunction

  task automatic idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; s0n = 0; s1 = 1; s2n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 2'b11; din = '0;
  endtask

  task automatic chk(input string tag);
    logic        ev;
    logic [17:0] ed;
    ev = ex_v && !oe_n;
    ed = ev ? ex_d : 18'h0;
    checks++;
    if (dout_valid !== ev || dout !== ed) begin
      failures++;
      $display("FAIL %s: dout_valid=%0b dout=%05h expected valid=%0b dout=%05h",
               tag, dout_valid, dout, ev, ed);
    end
  endtask

  task automatic go(input string tag);
    logic ph, ch, sel, wr;
    logic [1:0] mk;
    int lo, off;
    @(posedge clk);
    if (rq_v && rq_w) begin
      for (int i = 0; i < 2; i++)
        if (rq_mask[i]) mmem[rq_addr][9*i +: 9] = rq_data[9*i +: 9];
      ex_v = 0;
    end else if (rq_v) begin
      ex_v = 1; ex_d = mmem[rq_addr];
    end else ex_v = 0;
    ph  = !cpu_n && !s0n;
    ch  = !ctl_n;
    sel = !s0n && s1 && !s2n;
    wr  = !gw_n || !bwe_n;
    mk  = !gw_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
    rq_v = 0;
    if (ph || ch) begin
      m_on = sel; m_base = addr; m_cnt = 0; m_lin = lin;
      if (sel) begin
        rq_v = 1; rq_addr = addr; rq_w = ph ? 1'b0 : wr; rq_mask = mk; rq_data = din;
      end
    end else if (m_on && !adv_n) begin
      if (m_cnt == 3) m_on = 0;
      else begin
        m_cnt++;
        lo  = int'(m_base[1:0]);
        off = m_lin ? ((lo + m_cnt) % 4) : (lo ^ m_cnt);
        rq_v = 1; rq_addr = {m_base[9:2], 2'(off)}; rq_w = wr; rq_mask = mk; rq_data = din;
      end
    end
    @(negedge clk);
    chk(tag);
  endtask

  task automatic ctl_read(input logic [9:0] a, input logic order, input string tag);
    idle(); ctl_n = 0; addr = a; lin = order; go(tag);
  endtask

  task automatic advance(input string tag);
    idle(); adv_n = 0; go(tag);
  endtask

  initial begin
    #(20 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(); oe_n = 0; lin = 0; addr = '0;
    m_on = 0; m_lin = 0; m_base = '0; m_cnt = 0; rq_v = 0; rq_w = 0; rq_mask = 0;
    rq_addr = '0; rq_data = '0; ex_v = 0; ex_d = '0;
    for (int i = 0; i < 1024; i++) mmem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset");

    // R3: global write prefill with lane selects inactive
    for (int a = 0; a < 64; a++) begin
      idle(); ctl_n = 0; addr = 10'(a); gw_n = 0; bwe_n = 1; bw_n = 2'b11; din = pat(a);
      go("R3 prefill");
    end
    idle(); go("R3");
    // R2: single-beat reads, one per strobe
    for (int a = 0; a < 64; a++) ctl_read(10'(a), 0, "R2 single read");
    idle(); go("R2"); go("R2");

    // R7 / R8: every start offset, both orders
    for (int b = 0; b < 16; b++)
      for (int o = 0; o < 2; o++) begin
        ctl_read(10'(b), o[0], o[0] ? "R8 linear" : "R7 interleaved");
        for (int k = 0; k < 3; k++) advance(o[0] ? "R8 linear" : "R7 interleaved");
        idle(); go("R7 R8 tail"); go("R7 R8 tail");
      end

    // R4: per-lane writes, every select pattern, then read back
    for (int m = 0; m < 4; m++) begin
      idle(); ctl_n = 0; addr = 10'(40 + m); gw_n = 1; bwe_n = 0; bw_n = 2'(m);
      din = 18'h3FFFF ^ pat(m + 7); go("R4 lane write");
      ctl_read(10'(40 + m), 0, "R4 lane readback");
    end
    // R3: global write overrides inactive lane selects inside a burst
    idle(); ctl_n = 0; addr = 10'd44; gw_n = 0; bwe_n = 1; bw_n = 2'b11; din = 18'h12345;
    go("R3 burst gw");
    idle(); adv_n = 0; gw_n = 0; bwe_n = 0; bw_n = 2'b01; din = 18'h0ABCD; go("R3 burst gw");
    idle(); adv_n = 0; bwe_n = 0; bw_n = 2'b10; din = 18'h3C3C3; go("R4 burst lane");
    idle(); adv_n = 0; bwe_n = 0; bw_n = 2'b11; din = 18'h11111; go("R4 empty mask");
    ctl_read(10'd44, 0, "R4 burst readback");
    for (int k = 0; k < 3; k++) advance("R4 burst readback");
    idle(); go("R4"); go("R4");

    // R12: write burst then read on the very next edge
    idle(); ctl_n = 0; addr = 10'd48; lin = 1; gw_n = 0; din = 18'h2F00F; go("R12 write");
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 0; gw_n = 0; din = 18'(18'h01010 * (k + 2)); go("R12 write");
    end
    ctl_read(10'd49, 1, "R12 read after write");
    for (int k = 0; k < 3; k++) advance("R12 read after write");
    idle(); go("R12"); go("R12");

    // R9: pauses inside a burst
    ctl_read(10'd22, 0, "R9 pause");
    advance("R9 pause");
    idle(); go("R9 pause"); go("R9 pause");
    advance("R9 pause"); idle(); go("R9 pause");
    advance("R9 pause");
    idle(); go("R9"); go("R9");

    // R10: advances past the fourth beat, then a restart mid-burst
    ctl_read(10'd25, 1, "R10 end");
    for (int k = 0; k < 5; k++) advance("R10 end");
    idle(); go("R10"); go("R10");
    ctl_read(10'd30, 0, "R10 restart");
    advance("R10 restart");
    ctl_read(10'd35, 1, "R10 restart");
    for (int k = 0; k < 3; k++) advance("R10 restart");
    idle(); go("R10"); go("R10");

    // R5: deselecting controller strobes end a burst
    for (int v = 0; v < 3; v++) begin
      ctl_read(10'd4, 0, "R5 deselect");
      advance("R5 deselect");
      idle(); ctl_n = 0; addr = 10'd60;
      if (v == 0) s1 = 0; else if (v == 1) s0n = 1; else s2n = 1;
      go("R5 deselect");
      advance("R5 after deselect"); advance("R5 after deselect");
      idle(); go("R5"); go("R5");
    end

    // R6: processor strobe with sel0_n high is ignored; its beat is always a read
    ctl_read(10'd8, 0, "R6 ignored strobe");
    idle(); cpu_n = 0; s0n = 1; adv_n = 0; addr = 10'd50; go("R6 ignored strobe");
    advance("R6 ignored strobe"); advance("R6 ignored strobe");
    idle(); go("R6"); go("R6");
    idle(); cpu_n = 0; addr = 10'd20; gw_n = 0; bwe_n = 0; bw_n = 2'b00; din = 18'h3FFFF;
    go("R6 cpu read");
    idle(); cpu_n = 0; ctl_n = 0; addr = 10'd21; gw_n = 0; din = 18'h00001;
    go("R6 both strobes");
    ctl_read(10'd20, 0, "R6 unchanged");
    ctl_read(10'd21, 0, "R6 unchanged");
    idle(); go("R6"); go("R6");

    // R11: output enable gates the output without disturbing the burst
    ctl_read(10'd12, 1, "R11 oe");
    advance("R11 oe");
    oe_n = 1; advance("R11 oe high");
    #3; chk("R11 oe high mid-cycle");
    oe_n = 0; #1; chk("R11 oe low mid-cycle");
    advance("R11 oe");
    idle(); go("R11"); go("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule